// File: doc/BRIEF.md
# CAN Transmit Mailbox Request Manager

This block keeps track of transmit requests for a bank of CAN message mailboxes and feeds them one at a time to a bit-level CAN protocol engine. Software raises a request by writing ones into a per-mailbox pending register. It withdraws a request only through a separate cancel register. The block offers the lowest-numbered pending mailbox to the engine, as an index. The engine fetches identifier, control and data from mailbox storage elsewhere. The block also clamps the frame's data length code into a byte count for the engine.

The engine reports each finished frame with a result code. On success the mailbox's acknowledge bit is set and its request is retired. After lost arbitration or a bus error, the request stays pending and the mailbox is offered again. A cancelled request ends with an abort acknowledge. Both acknowledge registers are cleared by writing ones. A single interrupt line reports any acknowledge that passes a per-mailbox enable and a global enable.

Top module: `can_txmb_mgr`

## Requirements
- R1: Writing with `pendWe` sets the pending bit of every mailbox 1..NUM_MB-1 whose `wrData` bit is 1. The bit is visible on `pendingQ` after the next clock edge.
- R2: A frame that ends with `engDone` and `engResult` = 0 (success) sets that mailbox's `txAckQ` bit and clears its pending bit.
- R3: A frame that ends with `engResult` = 1 (lost arbitration) or 2 (bus error) leaves the pending bit set. The same mailbox is then offered again with `txReq`.
- R4: Writing 1 with `cancelWe` to a mailbox that is pending but not on the bus clears its pending bit and sets its `abortAckQ` bit at the next edge. A cancel of a mailbox that is not pending changes nothing.
- R5: A pending-register write whose data bits are 0 leaves the pending bits and the abort bits unchanged. Clearing a request this way is not possible.
- R6: `irq` equals `emptyIntEn` AND the OR over all mailboxes of ((`txAckQ` | `abortAckQ`) & `mbIntMask`).
- R7: `txByteCnt` equals `selDlc` when `selDlc` is 8 or less, and 8 otherwise.
- R8: Mailbox 0 is never pending and is never offered on `txMbIdx` while `txReq` is high.
- R9: While no frame is active, `txReq` is high exactly when a mailbox is pending, and `txMbIdx` is the lowest-numbered pending mailbox. Once `engStart` is taken, `txReq` stays low and `txMbIdx` holds the active mailbox until `engDone`, even if a lower-numbered request arrives.
- R10: A cancel aimed at the mailbox currently on the bus waits for the outcome. On success only `txAckQ` is set. On failure the pending bit is cleared and `abortAckQ` is set.
- R11: Writing 1 with `ackClrWe` or `abortClrWe` clears the matching bits of `txAckQ` or `abortAckQ`. Bits written 0 keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pendWe | input | 1 | Write strobe, pending register (ones set requests) |
| cancelWe | input | 1 | Write strobe, cancel register |
| ackClrWe | input | 1 | Write strobe, success-acknowledge clear |
| abortClrWe | input | 1 | Write strobe, abort-acknowledge clear |
| wrData | input | NUM_MB | Per-mailbox write data shared by all strobes |
| mbIntMask | input | NUM_MB | Per-mailbox interrupt enable |
| emptyIntEn | input | 1 | Global mailbox-empty interrupt enable |
| engStart | input | 1 | Engine takes the offered mailbox |
| engDone | input | 1 | Engine finished the active frame |
| engResult | input | 2 | Outcome: 0 success, 1 arbitration lost, 2 bus error |
| selDlc | input | 4 | Data length code read from the offered mailbox |
| txReq | output | 1 | A mailbox is offered to the engine |
| txMbIdx | output | IDX_W | Offered or active mailbox number |
| txByteCnt | output | 4 | Data bytes the engine sends |
| pendingQ | output | NUM_MB | Pending-request bits |
| txAckQ | output | NUM_MB | Success-acknowledge bits |
| abortAckQ | output | NUM_MB | Abort-acknowledge bits |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume the engine behaves:
- `engStart` comes only while `txReq` is high.
- `engDone` comes only while a frame is active.
- Start and done never fall in the same cycle.

The bench's engine responder follows that handshake strictly. It pulses start and then done on separate cycles. Software writes are driven only on cycles where the engine strobes are low. A cancel meant for the active frame is issued between start and done.

// File: rtl/can_txmb_pkg.sv
package can_txmb_pkg;

  // Frame outcome code reported by the protocol engine
  typedef enum logic [1:0] {
    RES_OK   = 2'd0,
    RES_ARB  = 2'd1,
    RES_ERR  = 2'd2,
    RES_RSVD = 2'd3
  } txResult_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic onBus;      // busIdx is active or being started this cycle
    logic frameOk;    // active frame finished without error
    logic frameFail;  // active frame lost arbitration or hit an error
  } ctlStrobe_t;

endpackage

// File: rtl/can_txmb_dp.sv
module can_txmb_dp
  import can_txmb_pkg::*;
#(
  parameter int NUM_MB = 32,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pendWe,
  input  logic              cancelWe,
  input  logic              ackClrWe,
  input  logic              abortClrWe,
  input  logic [NUM_MB-1:0] wrData,
  input  logic [NUM_MB-1:0] mbIntMask,
  input  logic              emptyIntEn,
  input  ctlStrobe_t        strb,
  input  logic [IDX_W-1:0]  busIdx,
  output logic              anyPend,
  output logic [IDX_W-1:0]  lowIdx,
  output logic [NUM_MB-1:0] pendQ,
  output logic [NUM_MB-1:0] ackQ,
  output logic [NUM_MB-1:0] abtQ,
  output logic              irq
);

  // Mailbox 0 never takes part in transmit requests
  localparam logic [NUM_MB-1:0] TX_MASK = {{(NUM_MB-1){1'b1}}, 1'b0};

  logic [NUM_MB-1:0] holdQ;
  logic [NUM_MB-1:0] busHot, doneHot, setReq, cancelReq;
  logic [NUM_MB-1:0] cancelNow, holdSet, holdEff, okHot, abortHot;
  logic [NUM_MB-1:0] ackClr, abtClr, pendNext, holdNext, ackNext, abtNext;
  logic [NUM_MB-1:0] irqSrc;

  always_comb begin
    busHot    = strb.onBus ? (NUM_MB'(1) << busIdx) : '0;
    doneHot   = (strb.frameOk || strb.frameFail) ? (NUM_MB'(1) << busIdx) : '0;
    setReq    = pendWe     ? (wrData & TX_MASK) : '0;
    cancelReq = cancelWe   ? (wrData & TX_MASK) : '0;
    ackClr    = ackClrWe   ? wrData : '0;
    abtClr    = abortClrWe ? wrData : '0;

    // A waiting mailbox is withdrawn at once.
    // The mailbox on the bus waits for its outcome.
    cancelNow = cancelReq & pendQ & ~busHot;
    holdSet   = cancelReq & pendQ & busHot;
    holdEff   = holdQ | holdSet;

    okHot     = strb.frameOk   ? doneHot : '0;
    abortHot  = strb.frameFail ? (doneHot & holdEff) : '0;

    pendNext  = (pendQ & ~okHot & ~abortHot & ~cancelNow) | setReq;
    holdNext  = holdEff & ~doneHot;
    ackNext   = (ackQ & ~ackClr) | okHot;
    abtNext   = (abtQ & ~abtClr) | abortHot | cancelNow;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ <= '0;
      holdQ <= '0;
      ackQ  <= '0;
      abtQ  <= '0;
    end else begin
      pendQ <= pendNext & TX_MASK;
      holdQ <= holdNext & TX_MASK;
      ackQ  <= ackNext & TX_MASK;
      abtQ  <= abtNext & TX_MASK;
    end
  end

  // Lowest-numbered pending mailbox wins
  always_comb begin
    lowIdx = '0;
    for (int i = NUM_MB - 1; i >= 1; i--) begin
      if (pendQ[i]) lowIdx = IDX_W'(i);
    end
    anyPend = |pendQ;
  end

  // Two-level interrupt gating
  assign irqSrc = (ackQ | abtQ) & mbIntMask;
  assign irq    = emptyIntEn & (|irqSrc);

  a_r2_ok_sets_ack : assert property (@(posedge clk) disable iff (!rstN)
    strb.frameOk |=> ackQ[$past(busIdx)]);

  a_r3_fail_keeps_pend : assert property (@(posedge clk) disable iff (!rstN)
    (strb.frameFail && !holdEff[busIdx]) |=> pendQ[$past(busIdx)]);

  a_r4_abort_from_pend : assert property (@(posedge clk) disable iff (!rstN)
    ((abtQ & ~$past(abtQ)) & ~$past(pendQ)) == '0);

  a_r10_ok_no_abort : assert property (@(posedge clk) disable iff (!rstN)
    strb.frameOk |=> !(abtQ[$past(busIdx)] && !$past(abtQ[busIdx])));

endmodule

// File: rtl/can_txmb_ctl.sv
module can_txmb_ctl
  import can_txmb_pkg::*;
#(
  parameter int NUM_MB = 32,
  parameter int IDX_W  = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             engStart,
  input  logic             engDone,
  input  logic [1:0]       engResult,
  input  logic             anyPend,
  input  logic [IDX_W-1:0] lowIdx,
  output logic             txReq,
  output logic [IDX_W-1:0] txMbIdx,
  output ctlStrobe_t       strb
);

  logic             busyQ;
  logic [IDX_W-1:0] activeQ;
  logic             takeIt;
  txResult_e        res;

  assign res    = txResult_e'(engResult);
  assign txReq  = !busyQ && anyPend;
  assign takeIt = txReq && engStart;

  // Selection is frozen while a frame is on the bus
  assign txMbIdx = busyQ ? activeQ : lowIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ   <= 1'b0;
      activeQ <= '0;
    end else if (takeIt) begin
      busyQ   <= 1'b1;
      activeQ <= lowIdx;
    end else if (busyQ && engDone) begin
      busyQ   <= 1'b0;
    end
  end

  always_comb begin
    strb.onBus     = busyQ || takeIt;
    strb.frameOk   = busyQ && engDone && (res == RES_OK);
    strb.frameFail = busyQ && engDone && (res != RES_OK);
  end

  a_r8_no_mb0_offer : assert property (@(posedge clk) disable iff (!rstN)
    txReq |-> (txMbIdx != '0));

  a_r9_hold_active : assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && !engDone) |=> (txMbIdx == $past(txMbIdx)) && !txReq);

endmodule

// File: rtl/can_txmb_mgr.sv
module can_txmb_mgr
  import can_txmb_pkg::*;
#(
  parameter int NUM_MB = 32,
  localparam int IDX_W = $clog2(NUM_MB)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pendWe,
  input  logic              cancelWe,
  input  logic              ackClrWe,
  input  logic              abortClrWe,
  input  logic [NUM_MB-1:0] wrData,
  input  logic [NUM_MB-1:0] mbIntMask,
  input  logic              emptyIntEn,
  input  logic              engStart,
  input  logic              engDone,
  input  logic [1:0]        engResult,
  input  logic [3:0]        selDlc,
  output logic              txReq,
  output logic [IDX_W-1:0]  txMbIdx,
  output logic [3:0]        txByteCnt,
  output logic [NUM_MB-1:0] pendingQ,
  output logic [NUM_MB-1:0] txAckQ,
  output logic [NUM_MB-1:0] abortAckQ,
  output logic              irq
);

  localparam logic [3:0] MAX_BYTES = 4'd8;

  ctlStrobe_t       strb;
  logic             anyPend;
  logic [IDX_W-1:0] lowIdx;

  can_txmb_ctl #(.NUM_MB(NUM_MB), .IDX_W(IDX_W)) ctl_i (
    .clk(clk), .rstN(rstN), .engStart(engStart), .engDone(engDone),
    .engResult(engResult), .anyPend(anyPend), .lowIdx(lowIdx),
    .txReq(txReq), .txMbIdx(txMbIdx), .strb(strb)
  );

  can_txmb_dp #(.NUM_MB(NUM_MB), .IDX_W(IDX_W)) dp_i (
    .clk(clk), .rstN(rstN), .pendWe(pendWe), .cancelWe(cancelWe),
    .ackClrWe(ackClrWe), .abortClrWe(abortClrWe), .wrData(wrData),
    .mbIntMask(mbIntMask), .emptyIntEn(emptyIntEn), .strb(strb),
    .busIdx(txMbIdx), .anyPend(anyPend), .lowIdx(lowIdx),
    .pendQ(pendingQ), .ackQ(txAckQ), .abtQ(abortAckQ), .irq(irq)
  );

  // Data length codes above 8 still send 8 bytes
  assign txByteCnt = (selDlc > MAX_BYTES) ? MAX_BYTES : selDlc;

  a_r6_irq_global_gate : assert property (@(posedge clk) disable iff (!rstN)
    !emptyIntEn |-> !irq);

  a_r7_byte_limit : assert property (@(posedge clk) disable iff (!rstN)
    txByteCnt <= MAX_BYTES);

endmodule

// File: tb/can_txmb_mgr_tb_top.sv
module can_txmb_mgr_tb_top;
  localparam int N  = 8;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic pendWe = 0, cancelWe = 0, ackClrWe = 0, abortClrWe = 0;
  logic [N-1:0] wrData = '0, mbIntMask = '1;
  logic emptyIntEn = 1'b1, engStart = 0, engDone = 0;
  logic [1:0] engResult = 2'd0;
  logic [3:0] selDlc = 4'd0;
  logic txReq, irq;
  logic [IW-1:0] txMbIdx;
  logic [3:0] txByteCnt;
  logic [N-1:0] pendingQ, txAckQ, abortAckQ;

  can_txmb_mgr #(.NUM_MB(N)) dut_i (
    .clk(clk), .rstN(rstN), .pendWe(pendWe), .cancelWe(cancelWe),
    .ackClrWe(ackClrWe), .abortClrWe(abortClrWe), .wrData(wrData),
    .mbIntMask(mbIntMask), .emptyIntEn(emptyIntEn), .engStart(engStart),
    .engDone(engDone), .engResult(engResult), .selDlc(selDlc),
    .txReq(txReq), .txMbIdx(txMbIdx), .txByteCnt(txByteCnt),
    .pendingQ(pendingQ), .txAckQ(txAckQ), .abortAckQ(abortAckQ), .irq(irq)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [N-1:0] ePend = '0, eAck = '0, eAbt = '0;

  function automatic logic [IW-1:0] lowestOf(logic [N-1:0] v);
    logic [IW-1:0] r = '0;
    for (int i = N - 1; i >= 1; i--) if (v[i]) r = IW'(i);
    return r;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // Full register and interrupt check; caller ensures no frame is active
  task automatic chkAll(string req);
    logic expIrq;
    expIrq = emptyIntEn & (|((eAck | eAbt) & mbIntMask));
    chk(pendingQ == ePend, req, "pending", int'(pendingQ), int'(ePend));
    chk(txAckQ == eAck, req, "ack", int'(txAckQ), int'(eAck));
    chk(abortAckQ == eAbt, req, "abort", int'(abortAckQ), int'(eAbt));
    chk(irq == expIrq, req, "irq", int'(irq), int'(expIrq));
    chk(txReq == (|ePend), req, "txReq", int'(txReq), int'(|ePend));
    if (|ePend)
      chk(txMbIdx == lowestOf(ePend), req, "txMbIdx", int'(txMbIdx), int'(lowestOf(ePend)));
  endtask

  // sel: 0 pending set, 1 cancel, 2 ack clear, 3 abort clear (idle only)
  task automatic wrReg(int sel, logic [N-1:0] d);
    wrData = d;
    case (sel)
      0: pendWe = 1;
      1: cancelWe = 1;
      2: ackClrWe = 1;
      default: abortClrWe = 1;
    endcase
    tick();
    pendWe = 0; cancelWe = 0; ackClrWe = 0; abortClrWe = 0;
    case (sel)
      0: ePend |= d & ~N'(1);
      1: begin eAbt |= d & ePend; ePend &= ~d; end
      2: eAck &= ~d;
      default: eAbt &= ~d;
    endcase
  endtask

  // Behavioural engine: take the offered mailbox, finish it with res
  task automatic frame(logic [1:0] res, bit cancelMid, string req);
    logic [IW-1:0] idx;
    idx = lowestOf(ePend);
    chk(txReq == 1'b1, req, "offer txReq", int'(txReq), 1);
    chk(txMbIdx == idx, req, "offer idx", int'(txMbIdx), int'(idx));
    engStart = 1;
    tick();
    engStart = 0;
    chk(txReq == 1'b0, req, "busy txReq", int'(txReq), 0);
    chk(txMbIdx == idx, req, "busy idx", int'(txMbIdx), int'(idx));
    if (cancelMid) begin
      wrData = N'(1) << idx;
      cancelWe = 1;
      tick();
      cancelWe = 0;
      chk(pendingQ == ePend, req, "held pending", int'(pendingQ), int'(ePend));
      chk(abortAckQ == eAbt, req, "held abort", int'(abortAckQ), int'(eAbt));
    end
    engResult = res;
    engDone = 1;
    tick();
    engDone = 0;
    if (res == 2'd0) begin
      eAck[idx] = 1'b1;
      ePend[idx] = 1'b0;
    end else if (cancelMid) begin
      eAbt[idx] = 1'b1;
      ePend[idx] = 1'b0;
    end
    chkAll(req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rstN = 1;
    tick();
    chkAll("reset");

    // R1 and R8: set everything, mailbox 0 must stay out
    wrReg(0, '1);
    chkAll("R1 R8");

    // R5: zero write changes nothing
    wrReg(0, '0);
    chkAll("R5");

    // R9 and R2: drain in priority order with successes
    while (|ePend) frame(2'd0, 0, "R9 R2");

    // R11: clear some acks, then the rest
    wrReg(2, 8'h0A);
    chkAll("R11 ack");
    wrReg(2, '1);
    chkAll("R11 ack all");

    // R3: arbitration loss and error both retry, then success
    wrReg(0, 8'h08);
    frame(2'd1, 0, "R3 arb");
    frame(2'd2, 0, "R3 err");
    frame(2'd0, 0, "R3 final");

    // R9: a lower request arriving mid-frame does not preempt
    wrReg(0, 8'h20);
    engStart = 1; tick(); engStart = 0;
    wrData = 8'h04; pendWe = 1; tick(); pendWe = 0; ePend |= 8'h04;
    chk(txReq == 1'b0, "R9", "no preempt txReq", int'(txReq), 0);
    chk(txMbIdx == 3'd5, "R9", "no preempt idx", int'(txMbIdx), 5);
    engResult = 2'd0; engDone = 1; tick(); engDone = 0;
    eAck[5] = 1'b1; ePend[5] = 1'b0;
    chkAll("R9 after");
    frame(2'd0, 0, "R9 next");

    // R4: cancel a waiting mailbox while another is on the bus
    wrReg(0, 8'h24);
    engStart = 1; tick(); engStart = 0;
    wrData = 8'h20; cancelWe = 1; tick(); cancelWe = 0;
    eAbt[5] = 1'b1; ePend[5] = 1'b0;
    chk(pendingQ == ePend, "R4", "cancel waiting pend", int'(pendingQ), int'(ePend));
    chk(abortAckQ == eAbt, "R4", "cancel waiting abort", int'(abortAckQ), int'(eAbt));
    engResult = 2'd0; engDone = 1; tick(); engDone = 0;
    eAck[2] = 1'b1; ePend[2] = 1'b0;
    chkAll("R4 done");

    // R4: cancel of a non-pending mailbox has no effect
    wrReg(1, 8'h40);
    chkAll("R4 idle cancel");

    // R10: cancel on bus, success wins; cancel on bus, failure aborts
    wrReg(0, 8'h02);
    frame(2'd0, 1, "R10 ok");
    wrReg(0, 8'h02);
    frame(2'd2, 1, "R10 fail");
    wrReg(3, '1);
    wrReg(2, '1);
    chkAll("R11 clear all");

    // R9 R8 R4 sweep: every request pattern, offered index then cancel
    for (int p = 0; p < 256; p++) begin
      wrReg(0, N'(p));
      chkAll("R9 sweep");
      wrReg(1, '1);
      chkAll("R4 sweep");
      wrReg(3, '1);
    end

    // R6: interrupt gating over masks and global enable
    eAck = '0; eAbt = '0;
    wrReg(0, 8'h06);
    frame(2'd0, 0, "R6 setup");
    wrReg(1, 8'h04);
    for (int g = 0; g < 2; g++) begin
      for (int m = 0; m < 256; m++) begin
        emptyIntEn = g[0];
        mbIntMask = N'(m);
        #1;
        chk(irq == (g[0] & (|((eAck | eAbt) & N'(m)))), "R6", "irq",
            int'(irq), int'(g[0] & (|((eAck | eAbt) & N'(m)))));
      end
    end
    emptyIntEn = 1'b1; mbIntMask = '1;

    // R7: byte count clamp
    for (int d = 0; d < 16; d++) begin
      selDlc = 4'(d);
      #1;
      chk(txByteCnt == ((d > 8) ? 4'd8 : 4'(d)), "R7", "bytes",
          int'(txByteCnt), (d > 8) ? 8 : d);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule